// File: doc/BRIEF.md
# Bus controller instruction sequencer

This block steps through a table of scheduling instructions for a command/response serial bus controller. A host fills a local table memory and a major frame counter while the block is idle. A start pulse then makes the sequencer run from entry 0. Each entry holds an opcode and two 16-bit parameters. The sequencer fetches one entry at a time, moves its program counter, and passes transfer work to a separate transfer engine over a request/done handshake. It also handles subroutine calls on an 8-deep return stack, absolute jumps, relative branches that can raise an interrupt, stalls until an external trigger arrives, one-cycle trigger strobes, and a counted loop against the major frame counter.

Each table entry is 36 bits wide: bits 35:32 hold the opcode, bits 31:16 hold parameter A and bits 15:0 hold parameter B. Labels and branch offsets use the low address bits of parameter A, so all address arithmetic wraps modulo the table depth (64 entries by default). The control state machine has these states:
- IDLE waits for start.
- FETCH reads the entry at the program counter.
- EXEC decodes that entry.
- PAIR checks the second half of a paired transfer.
- XFER holds the request until done.
- TRIG waits for the trigger input.
- HALT is entered on any error and left only by reset.

Transitions: IDLE goes to FETCH on start. FETCH always goes to EXEC. EXEC goes to PAIR, XFER, TRIG or HALT, or back to FETCH. PAIR goes to XFER or HALT. XFER goes to FETCH on done. TRIG goes to FETCH on the trigger.

Top module: `bc_instr_seq`

## Requirements
- R1: After reset, xfer_req, irq, trig_out, frame_sync and err are low. Nothing runs until a start pulse, which begins execution at entry 0.
- R2: Opcode 1 (transfer) and opcode 2 (high-speed transfer) drive xfer_id from parameter A and raise xfer_req. Opcode 2 also sets xfer_hs. xfer_req and xfer_id stay steady until xfer_done, and execution then moves to the next entry.
- R3: A transfer entry with parameter B bit 15 set is the first half of a pair. The following entry must be opcode 2 with a type code in parameter B bits 2:0 between 1 and 5. The pair makes one request with xfer_pair high, xfer_id2 taken from the second entry's parameter A and xfer_type set to its code, and execution then resumes two entries on. A bad second entry sets err.
- R4: Opcode 3 (call) pushes the address of the next entry and jumps to the label. Opcode 4 (return) resumes at the address most recently pushed, and calls may nest.
- R5: The return stack holds 8 addresses. A ninth nested call, or a return with an empty stack, sets err. The sequencer then halts, and err stays set until reset.
- R6: Opcode 5 (jump) continues at the label.
- R7: Opcode 6 (branch) moves the program counter by the offset in parameter A, and an offset of 1 means the next entry. Parameter B bit 0 = 0 moves forward and 1 moves backward. The result wraps modulo the table depth.
- R8: When a branch has parameter B bit 1 set, irq is high for exactly one cycle, in the cycle after the branch executes. Without that bit irq stays low.
- R9: Opcode 7 (wait) stalls until trig_in is sampled high, then continues at the next entry. When parameter B bit 1 is set, frame_sync pulses for one cycle as the trigger is taken. When that bit is clear, frame_sync stays low.
- R10: Opcode 8 (strobe) makes trig_out high for exactly one clock, then continues at the next entry.
- R11: Opcode 9 first decrements the major frame counter unless it is already zero. If the result is zero, execution jumps to the label; otherwise it falls through. A loaded count v therefore runs the loop body max(v,1) times.
- R12: Any other opcode, including 0, sets err and halts the sequencer with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Host write strobe for the table |
| tbl_waddr | input | AW | Host write address |
| tbl_wdata | input | 36 | Host write data: {opcode, param A, param B} |
| mfc_ld | input | 1 | Load the major frame counter |
| mfc_val | input | CNT_W | Value to load into the counter |
| start | input | 1 | Begin execution at entry 0 |
| xfer_req | output | 1 | Transfer request to the transfer engine |
| xfer_id | output | 16 | Transfer identifier |
| xfer_id2 | output | 16 | Second identifier of a paired transfer |
| xfer_hs | output | 1 | Request comes from a high-speed transfer entry |
| xfer_pair | output | 1 | Request is a paired two-entry transfer |
| xfer_type | output | 3 | Type code of a paired transfer |
| xfer_done | input | 1 | Transfer engine completion |
| trig_in | input | 1 | External trigger input |
| trig_out | output | 1 | One-cycle trigger strobe |
| frame_sync | output | 1 | Minor-frame resynchronisation pulse |
| irq | output | 1 | One-cycle branch interrupt |
| err | output | 1 | Sticky error; the sequencer is halted |

## Verification
Almost every fault in the program counter, the stack pointer or the frame counter shows up at the ports on the next transfer request. The request carries the wrong identifier, or it never comes. A fault can also show up as err, which rises within two cycles of the faulty decode. The bench sweeps branch offsets and directions, call depths around the stack limit, loaded frame counts, and all pair type codes. It compares the sequence of requested identifiers, and the counts of irq, trig_out and frame_sync pulses, against values it derives from the table it wrote.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        OP_XFER    = 4'd1,
        OP_XFER_HS = 4'd2,
        OP_CALL    = 4'd3,
        OP_RET     = 4'd4,
        OP_JUMP    = 4'd5,
        OP_BRANCH  = 4'd6,
        OP_WAIT    = 4'd7,
        OP_STROBE  = 4'd8,
        OP_DJZ     = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_PAIR,
        S_XFER,
        S_TRIG,
        S_HALT
    } st_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] pa;
        logic [15:0] pb;
    } entry_t;

    localparam int PAIR_BIT  = 15;
    localparam int DIR_BIT   = 0;
    localparam int FLAG_BIT  = 1;
    localparam int TYPE_MIN  = 1;
    localparam int TYPE_MAX  = 5;

endpackage

// File: rtl/seq_table_mem.sv
module seq_table_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 6,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    logic [W-1:0]  slot [DEPTH];
    logic [CW-1:0] cnt;
    logic [IW-1:0] top_idx;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = IW'(cnt - CW'(1));
    assign dout    = empty ? '0 : slot[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            slot[IW'(cnt)] <= din;
            cnt            <= cnt + CW'(1);
        end else if (pop) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R5: the sequencer must never push into a full stack
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R5: nor pop an empty one
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/seq_frame_cnt.sv
module seq_frame_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    output logic          zero_next
);

    logic [CW-1:0] cnt;

    assign zero_next = (cnt <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R11: a counter already at zero stays at zero when decremented
    p_dec_floor_r11: assert property (@(posedge clk) disable iff (rst)
        (dec && !ld && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/bc_instr_seq.sv
module bc_instr_seq
    import seq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int STK_DEPTH = 8,
    parameter int CNT_W     = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int EW       = $bits(entry_t)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbl_we,
    input  logic [AW-1:0]    tbl_waddr,
    input  logic [EW-1:0]    tbl_wdata,
    input  logic             mfc_ld,
    input  logic [CNT_W-1:0] mfc_val,
    input  logic             start,
    output logic             xfer_req,
    output logic [15:0]      xfer_id,
    output logic [15:0]      xfer_id2,
    output logic             xfer_hs,
    output logic             xfer_pair,
    output logic [2:0]       xfer_type,
    input  logic             xfer_done,
    input  logic             trig_in,
    output logic             trig_out,
    output logic             frame_sync,
    output logic             irq,
    output logic             err
);

    st_e           state, state_d;
    logic [AW-1:0] pc, pc_d, rd_addr;
    logic [EW-1:0] rdata;
    entry_t        ent;
    logic [AW-1:0] label;

    logic [15:0]   id_q, id_d, id2_q, id2_d;
    logic          hs_q, hs_d, pair_q, pair_d, syn_q, syn_d;
    logic [2:0]    type_q, type_d;

    logic          push, pop, dec;
    logic [AW-1:0] stk_top;
    logic          stk_full, stk_empty, mfc_zero_next;
    logic          irq_d, strobe_d, sync_d, fail;

    assign ent     = entry_t'(rdata);
    assign label   = ent.pa[AW-1:0];
    assign rd_addr = (state == S_EXEC) ? pc + AW'(1) : pc;

    seq_table_mem #(.DEPTH(DEPTH), .W(EW)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    seq_ret_stack #(.DEPTH(STK_DEPTH), .W(AW)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (pc + AW'(1)),
        .dout  (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    seq_frame_cnt #(.CW(CNT_W)) u_mfc (
        .clk       (clk),
        .rst       (rst),
        .ld        (mfc_ld),
        .ld_val    (mfc_val),
        .dec       (dec),
        .zero_next (mfc_zero_next)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d  = state;
        pc_d     = pc;
        id_d     = id_q;
        id2_d    = id2_q;
        hs_d     = hs_q;
        pair_d   = pair_q;
        type_d   = type_q;
        syn_d    = syn_q;
        push     = 1'b0;
        pop      = 1'b0;
        dec      = 1'b0;
        irq_d    = 1'b0;
        strobe_d = 1'b0;
        sync_d   = 1'b0;
        fail     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    pc_d    = '0;
                    state_d = S_FETCH;
                end
            end
            S_FETCH: state_d = S_EXEC;
            S_EXEC: begin
                state_d = S_FETCH;
                case (ent.op)
                    OP_XFER, OP_XFER_HS: begin
                        id_d    = ent.pa;
                        id2_d   = '0;
                        type_d  = '0;
                        hs_d    = (ent.op == OP_XFER_HS);
                        pair_d  = ent.pb[PAIR_BIT];
                        state_d = ent.pb[PAIR_BIT] ? S_PAIR : S_XFER;
                    end
                    OP_CALL: begin
                        if (stk_full) begin
                            fail = 1'b1;
                        end else begin
                            push = 1'b1;
                            pc_d = label;
                        end
                    end
                    OP_RET: begin
                        if (stk_empty) begin
                            fail = 1'b1;
                        end else begin
                            pop  = 1'b1;
                            pc_d = stk_top;
                        end
                    end
                    OP_JUMP: pc_d = label;
                    OP_BRANCH: begin
                        pc_d  = ent.pb[DIR_BIT] ? pc - label : pc + label;
                        irq_d = ent.pb[FLAG_BIT];
                    end
                    OP_WAIT: begin
                        syn_d   = ent.pb[FLAG_BIT];
                        state_d = S_TRIG;
                    end
                    OP_STROBE: begin
                        strobe_d = 1'b1;
                        pc_d     = pc + AW'(1);
                    end
                    OP_DJZ: begin
                        dec  = 1'b1;
                        pc_d = mfc_zero_next ? label : pc + AW'(1);
                    end
                    default: fail = 1'b1;
                endcase
            end
            S_PAIR: begin
                if (ent.op == OP_XFER_HS &&
                    int'(ent.pb[2:0]) >= TYPE_MIN &&
                    int'(ent.pb[2:0]) <= TYPE_MAX) begin
                    id2_d   = ent.pa;
                    type_d  = ent.pb[2:0];
                    state_d = S_XFER;
                end else begin
                    fail = 1'b1;
                end
            end
            S_XFER: begin
                if (xfer_done) begin
                    pc_d    = pc + (pair_q ? AW'(2) : AW'(1));
                    state_d = S_FETCH;
                end
            end
            S_TRIG: begin
                if (trig_in) begin
                    sync_d  = syn_q;
                    pc_d    = pc + AW'(1);
                    state_d = S_FETCH;
                end
            end
            S_HALT: state_d = S_HALT;
        endcase
        if (fail) begin
            state_d = S_HALT;
        end
    end

    // State register and sequencer context
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            pc     <= '0;
            id_q   <= '0;
            id2_q  <= '0;
            hs_q   <= 1'b0;
            pair_q <= 1'b0;
            type_q <= '0;
            syn_q  <= 1'b0;
        end else begin
            state  <= state_d;
            pc     <= pc_d;
            id_q   <= id_d;
            id2_q  <= id2_d;
            hs_q   <= hs_d;
            pair_q <= pair_d;
            type_q <= type_d;
            syn_q  <= syn_d;
        end
    end

    // Registered pulse and flag outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            trig_out   <= 1'b0;
            frame_sync <= 1'b0;
            err        <= 1'b0;
        end else begin
            irq        <= irq_d;
            trig_out   <= strobe_d;
            frame_sync <= sync_d;
            err        <= err | fail;
        end
    end

    assign xfer_req  = (state == S_XFER);
    assign xfer_id   = id_q;
    assign xfer_id2  = id2_q;
    assign xfer_hs   = hs_q;
    assign xfer_pair = pair_q;
    assign xfer_type = type_q;

    // R2: request and identifier hold until the engine answers
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_id)));
    // R8: interrupt is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R10: strobe is a single-cycle pulse
    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);
    // R9: resynchronisation only follows a sampled trigger
    p_sync_after_trig_r9: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> $past(trig_in));
    // R5: error flag is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R12: a halted sequencer requests nothing
    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        err |-> !xfer_req);

endmodule

// File: tb/sim_bc_instr_seq.sv
`timescale 1ns/1ps
module sim_bc_instr_seq;

    localparam int AW = 6;
    localparam int ND = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [AW-1:0] tbl_waddr = '0;
    logic [35:0] tbl_wdata = '0;
    logic        mfc_ld = 1'b0;
    logic [15:0] mfc_val = '0;
    logic        start = 1'b0;
    logic        xfer_req, xfer_hs, xfer_pair;
    logic [15:0] xfer_id, xfer_id2;
    logic [2:0]  xfer_type;
    logic        xfer_done = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_out, frame_sync, irq, err;

    int checks = 0;
    int errors = 0;
    int irq_n, trig_hi, trig_rise, sync_n;
    logic trig_prev;

    always #4 clk = ~clk;

    bc_instr_seq u0 (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .mfc_ld(mfc_ld), .mfc_val(mfc_val),
        .start(start), .xfer_req(xfer_req), .xfer_id(xfer_id),
        .xfer_id2(xfer_id2), .xfer_hs(xfer_hs), .xfer_pair(xfer_pair),
        .xfer_type(xfer_type), .xfer_done(xfer_done), .trig_in(trig_in),
        .trig_out(trig_out), .frame_sync(frame_sync), .irq(irq), .err(err)
    );

    always @(negedge clk) begin
        if (rst) begin
            irq_n = 0; trig_hi = 0; trig_rise = 0; sync_n = 0; trig_prev = 1'b0;
        end else begin
            irq_n     = irq_n + int'(irq);
            sync_n    = sync_n + int'(frame_sync);
            trig_hi   = trig_hi + int'(trig_out);
            trig_rise = trig_rise + int'(trig_out && !trig_prev);
            trig_prev = trig_out;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input int op, input int pa, input int pb);
        tbl_we    = 1'b1;
        tbl_waddr = AW'(a);
        tbl_wdata = {4'(op), 16'(pa), 16'(pb)};
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // every entry becomes a plain transfer whose id equals its address
    task automatic fill();
        for (int i = 0; i < ND; i++) put(i, 1, i, 0);
    endtask

    task automatic restart(input int mfc);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst     = 1'b0;
        mfc_ld  = 1'b1;
        mfc_val = 16'(mfc);
        @(negedge clk);
        mfc_ld = 1'b0;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    logic        g_got, g_hs, g_pair;
    logic [15:0] g_id, g_id2;
    logic [2:0]  g_typ;

    task automatic wait_xfer(input int limit, input int hold);
        g_got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (xfer_req) begin
                g_got = 1'b1; g_id = xfer_id; g_id2 = xfer_id2;
                g_hs = xfer_hs; g_pair = xfer_pair; g_typ = xfer_type;
                for (int h = 0; h < hold; h++) begin
                    @(negedge clk);
                    chk("R2 request held", int'(xfer_req), 1);
                    chk("R2 id held", int'(xfer_id), int'(g_id));
                end
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
                return;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and idle until start
        fill();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 req at reset", int'(xfer_req), 0);
        chk("R1 irq at reset", int'(irq), 0);
        chk("R1 trig_out at reset", int'(trig_out), 0);
        chk("R1 frame_sync at reset", int'(frame_sync), 0);
        chk("R1 err at reset", int'(err), 0);
        rst = 1'b0;
        wait_xfer(20, 0);
        chk("R1 no run before start", int'(g_got), 0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_xfer(50, 3);
        chk("R1 first entry is 0", int'(g_id), 0);
        chk("R2 plain not hs", int'(g_hs), 0);
        wait_xfer(50, 0);
        chk("R2 next entry", int'(g_id), 1);

        // R2: high-speed single transfer
        put(0, 2, 77, 0);
        restart(0);
        wait_xfer(50, 2);
        chk("R2 hs id", int'(g_id), 77);
        chk("R2 hs flag", int'(g_hs), 1);
        chk("R2 hs not pair", int'(g_pair), 0);

        // R3: paired transfers over every type code
        for (int t = 0; t < 8; t++) begin
            fill();
            put(0, 1, 11, 16'h8000);
            put(1, 2, 12, t);
            restart(0);
            wait_xfer(50, 0);
            if (t >= 1 && t <= 5) begin
                chk("R3 pair id", int'(g_id), 11);
                chk("R3 pair id2", int'(g_id2), 12);
                chk("R3 pair flag", int'(g_pair), 1);
                chk("R3 pair type", int'(g_typ), t);
                wait_xfer(50, 0);
                chk("R3 resume two on", int'(g_id), 2);
                chk("R3 no err", int'(err), 0);
            end else begin
                chk("R3 bad type no req", int'(g_got), 0);
                chk("R3 bad type err", int'(err), 1);
            end
        end
        // R3: second half with wrong opcode
        fill();
        put(0, 1, 11, 16'h8000);
        restart(0);
        wait_xfer(50, 0);
        chk("R3 bad second opcode err", int'(err), 1);

        // R4: nested call and return
        fill();
        put(0, 3, 30, 0); put(30, 3, 35, 0); put(36, 4, 0, 0); put(32, 4, 0, 0);
        restart(0);
        wait_xfer(60, 0); chk("R4 inner subtable", int'(g_id), 35);
        wait_xfer(60, 0); chk("R4 return to outer", int'(g_id), 31);
        wait_xfer(60, 0); chk("R4 return to main", int'(g_id), 1);

        // R5: call depth sweep around the stack limit
        for (int d = 1; d <= 9; d++) begin
            fill();
            put(0, 5, 40, 0);
            for (int j = 0; j < d; j++) put(40 + j, 3, 41 + j, 0);
            restart(0);
            wait_xfer(100, 0);
            if (d <= 8) begin
                chk("R5 depth ok req", int'(g_got), 1);
                chk("R5 depth ok id", int'(g_id), 40 + d);
                chk("R5 depth ok err", int'(err), 0);
            end else begin
                chk("R5 overflow no req", int'(g_got), 0);
                chk("R5 overflow err", int'(err), 1);
            end
        end
        fill();
        put(0, 4, 0, 0);
        restart(0);
        wait_xfer(40, 0);
        chk("R5 underflow no req", int'(g_got), 0);
        chk("R5 underflow err", int'(err), 1);
        repeat (10) @(negedge clk);
        chk("R5 err sticky", int'(err), 1);

        // R6: absolute jump
        fill();
        put(0, 5, 45, 0);
        restart(0);
        wait_xfer(50, 0);
        chk("R6 jump target", int'(g_id), 45);

        // R7 R8: branch offset and direction sweep
        for (int off = 1; off < 20; off++) begin
            for (int dir = 0; dir < 2; dir++) begin
                fill();
                put(0, 5, 20, 0);
                put(20, 6, off, dir + 2 * (off % 2));
                restart(0);
                wait_xfer(60, 0);
                chk("R7 branch target", int'(g_id), dir ? 20 - off : 20 + off);
                chk("R8 irq count", irq_n, off % 2);
            end
        end
        // R7: wrap modulo depth in both directions
        fill(); put(0, 5, 20, 0); put(20, 6, 50, 0);
        restart(0); wait_xfer(60, 0);
        chk("R7 forward wrap", int'(g_id), 6);
        fill(); put(0, 5, 20, 0); put(20, 6, 30, 1);
        restart(0); wait_xfer(60, 0);
        chk("R7 backward wrap", int'(g_id), 54);

        // R9: trigger wait with and without resync
        for (int s = 0; s < 2; s++) begin
            fill();
            put(0, 7, 0, 2 * s);
            restart(0);
            wait_xfer(30, 0);
            chk("R9 stalled", int'(g_got), 0);
            trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
            wait_xfer(40, 0);
            chk("R9 continues", int'(g_id), 1);
            chk("R9 frame_sync count", sync_n, s);
        end

        // R10: strobes
        fill();
        put(0, 8, 0, 0); put(1, 8, 0, 0);
        restart(0);
        wait_xfer(50, 0);
        chk("R10 after strobes", int'(g_id), 2);
        chk("R10 strobe pulses", trig_rise, 2);
        chk("R10 strobe width", trig_hi, 2);

        // R11: counted loop sweep
        for (int v = 0; v <= 5; v++) begin
            int n7;
            n7 = 0;
            fill();
            put(0, 1, 7, 0); put(1, 9, 10, 0); put(2, 5, 0, 0); put(10, 1, 200, 0);
            restart(v);
            for (int k = 0; k < 12; k++) begin
                wait_xfer(50, 0);
                if (!g_got || g_id != 16'd7) break;
                n7++;
            end
            chk("R11 loop count", n7, (v > 1) ? v : 1);
            chk("R11 exit target", int'(g_id), 200);
        end

        // R12: undefined opcodes
        for (int op = 10; op < 16; op += 5) begin
            fill();
            put(0, op, 0, 0);
            restart(0);
            wait_xfer(30, 0);
            chk("R12 no req", int'(g_got), 0);
            chk("R12 err", int'(err), 1);
        end
        fill();
        put(0, 0, 0, 0);
        restart(0);
        wait_xfer(30, 0);
        chk("R12 opcode zero err", int'(err), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule